// File: doc/BRIEF.md
# Configurable Serial Transmitter (Asynchronous / Synchronous)

This block is the transmit side of a serial port. Software programs it through an 8-bit control register and an 8-bit baud reload register, then hands it bytes through a data-write strobe. Each byte goes into a one-byte holding buffer. When the shift register is free, the byte moves from the buffer into the shift register, and the buffer is then ready for the next byte.

There are two ways to send a character:
- **Asynchronous mode:** a framed character on a line that idles high.
- **Synchronous half-duplex mode:** a bare 8- or 9-bit word. In this mode the block either generates the shift clock itself (master) or follows a clock from outside (slave).

A status bit in the control register reads 1 whenever the shift register is empty. In synchronous mode, either receive-enable input pauses the block and releases both serial pins.

Top module: `sertx_top`

## Requirements
- R1: After reset the control register (address 0) reads 0x02, `txd_o` is 1 and `ck_o` is 0.
- R2: The control register at address 0 has this layout:
  - bit 7: clock master.
  - bit 6: ninth-bit enable.
  - bit 5: transmit enable.
  - bit 4: synchronous mode.
  - bit 3: always reads 0.
  - bit 2: fast baud.
  - bit 1: read-only shift-empty status.
  - bit 0: ninth data bit.

  The baud reload register at address 1 reads back the value written to it.
- R3: An asynchronous frame is one low start bit, then the data bits LSB first, then one high stop bit. Each bit lasts 16·(reload+1) clocks when fast baud is 1 and 64·(reload+1) clocks when it is 0. The line idles high.
- R4: With ninth-bit enable set, a ninth data bit follows bit 7. Its value is control bit 0, captured when the shift register is loaded. With ninth-bit enable clear, exactly 8 data bits are sent.
- R5: The shift-empty status reads 0 from the load until the last bit has ended. A byte already waiting in the buffer is loaded at the end of the stop bit, so its start bit follows with no idle time and the status stays 0 in between.
- R6: While transmit enable is 0, no transmission starts, the line stays high and the status reads 1. A buffered byte is held and is sent once transmit enable is set.
- R7: Synchronous master mode:
  - The clock idles low and has a period of 4·(reload+1) clocks; the fast-baud bit does not change it.
  - Data goes out LSB first, with no start or stop bit, and changes only after falling clock edges.
- R8: Synchronous slave mode:
  - `ck_oe` is 0.
  - The first data bit is presented at load.
  - Each falling edge of `ck_i` that follows a rising edge moves the data to the next bit.
  - After the last such falling edge the status returns to 1.
- R9: In synchronous mode, if `rx_single_en` or `rx_cont_en` is 1:
  - `txd_oe` and `ck_oe` are 0.
  - The transmission is frozen: no clock edges and no status change.
  - Once both inputs are 0 again, the transmission continues and completes intact.
- R10: With `port_en` at 0, `txd_oe` and `ck_oe` are both 0.
- R11: In asynchronous mode the clock-master bit has no effect: `ck_oe` stays 0 and the frame is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Serial port enable; gates the pin output enables |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the control register, 1 the baud reload register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| dat_we | input | 1 | Transmit data write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| rx_single_en | input | 1 | Single-receive request; overrides transmission in synchronous mode |
| rx_cont_en | input | 1 | Continuous-receive request; overrides transmission in synchronous mode |
| txd_o | output | 1 | Serial data out |
| txd_oe | output | 1 | Output enable for `txd_o` |
| ck_i | input | 1 | Clock pin input, used in synchronous slave mode |
| ck_o | output | 1 | Clock pin output in synchronous master mode |
| ck_oe | output | 1 | Output enable for `ck_o` |

## Verification
The hardest situations to reach from the ports depend on exact timing:
- A second byte has to be written while the first is already in the shift register, so that the stop-to-start hand-over of R5 happens.
- A receive request has to arrive in the middle of a synchronous master word, after some clock edges have gone out.

The bench polls the status bit after the first write, so the second write lands in the first frame's start bit. For the freeze test, it counts rising clock edges and raises the receive request after the second one. It then watches for 40 cycles that neither the clock nor the status moves, and finally checks that the whole word arrives. The asynchronous frames are checked with random reload values, speeds, character lengths and ninth bits, drawn from a fixed seed.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;
    localparam int DATA_W  = 8;
    localparam int DIV_W   = 8;
    localparam int SH_FAST = 4;   // 16 clocks per unit
    localparam int SH_SLOW = 6;   // 64 clocks per unit
    localparam int SH_SYNC = 1;   // half of a 4-clock period
    localparam int CNT_W   = DIV_W + SH_SLOW + 1;
    localparam int FRAME_W = DATA_W + 3;
    localparam int LEFT_W  = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic clk_master;
        logic nine;
        logic tx_on;
        logic sync_mode;
        logic rsvd;
        logic fast;
        logic sr_empty;
        logic bit9;
    } ctl_t;

    typedef enum logic {ADDR_CTL = 1'b0, ADDR_DIV = 1'b1} addr_e;

    // Clocks between divider ticks: one bit (async) or one half clock (sync).
    function automatic logic [CNT_W-1:0] tick_limit(input logic sync,
                                                    input logic fast,
                                                    input logic [DIV_W-1:0] div);
        logic [CNT_W-1:0] base;
        base = CNT_W'(div) + CNT_W'(1);
        if (sync)      return base << SH_SYNC;
        else if (fast) return base << SH_FAST;
        else           return base << SH_SLOW;
    endfunction

    // Shift register image; bit 0 goes out first.
    function automatic logic [FRAME_W-1:0] frame_word(input logic sync,
                                                      input logic nine,
                                                      input logic bit9,
                                                      input logic [DATA_W-1:0] data);
        if (sync) return {2'b11, bit9, data};
        else      return {1'b1, (nine ? bit9 : 1'b1), data, 1'b0};
    endfunction

    // Number of bit steps after the first bit.
    function automatic logic [LEFT_W-1:0] frame_last(input logic sync, input logic nine);
        if (sync) return LEFT_W'(DATA_W - 1 + int'(nine));
        else      return LEFT_W'(DATA_W + 1 + int'(nine));
    endfunction
endpackage

// File: rtl/sertx_regs.sv
`timescale 1ns/1ps
module sertx_regs
    import sertx_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int VW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic          reg_addr,
    input  logic [7:0]    reg_wdata,
    input  logic          dat_we,
    input  logic [DW-1:0] dat_wdata,
    input  logic          take,
    input  logic          trmt,
    output ctl_t          ctl,
    output logic [VW-1:0] div,
    output logic          buf_full,
    output logic [DW-1:0] buf_data,
    output logic [7:0]    rdata
);
    ctl_t wr_img;
    ctl_t rd_img;

    always_comb begin
        wr_img          = ctl_t'(reg_wdata);
        wr_img.rsvd     = 1'b0;
        wr_img.sr_empty = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
            div <= '0;
        end else if (reg_we) begin
            if (addr_e'(reg_addr) == ADDR_CTL) ctl <= wr_img;
            else                               div <= reg_wdata[VW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_full <= 1'b0;
            buf_data <= '0;
        end else if (dat_we) begin
            buf_full <= 1'b1;
            buf_data <= dat_wdata;
        end else if (take) begin
            buf_full <= 1'b0;
        end
    end

    always_comb begin
        rd_img          = ctl;
        rd_img.rsvd     = 1'b0;
        rd_img.sr_empty = trmt;
        if (addr_e'(reg_addr) == ADDR_CTL) rdata = rd_img;
        else                               rdata = 8'(div);
    end
endmodule

// File: rtl/sertx_baud.sv
`timescale 1ns/1ps
module sertx_baud #(
    parameter int CW = sertx_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic [CW-1:0] limit,
    output logic          tick
);
    logic [CW-1:0] cnt;

    assign tick = run && !clear && (cnt == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (run)     cnt <= tick ? '0 : cnt + CW'(1);
    end
endmodule

// File: rtl/sertx_clock.sv
`timescale 1ns/1ps
module sertx_clock #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic master,
    input  logic busy,
    input  logic active,
    input  logic tick,
    input  logic ck_pin,
    output logic rise_ev,
    output logic fall_ev,
    output logic ck_drv
);
    logic [STAGES-1:0] sy;
    logic              sy_d;
    logic              ext_rise;
    logic              ext_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            sy   <= '0;
            sy_d <= 1'b0;
        end else begin
            sy   <= {sy[STAGES-2:0], ck_pin};
            sy_d <= sy[STAGES-1];
        end
    end

    assign ext_rise = sy[STAGES-1] && !sy_d;
    assign ext_fall = !sy[STAGES-1] && sy_d;

    always_ff @(posedge clk) begin
        if (rst || !busy)                ck_drv <= 1'b0;
        else if (master && active && tick) ck_drv <= !ck_drv;
    end

    assign rise_ev = active && (master ? (tick && !ck_drv) : ext_rise);
    assign fall_ev = active && (master ? (tick &&  ck_drv) : ext_fall);
endmodule

// File: rtl/sertx_shift.sv
`timescale 1ns/1ps
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FRAME_W,
    parameter int LW = LEFT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          run,
    input  logic          sync,
    input  logic          nine,
    input  logic          bit9,
    input  logic          buf_full,
    input  logic [DW-1:0] buf_data,
    input  logic          bit_tick,
    input  logic          rise_ev,
    input  logic          fall_ev,
    output logic          busy,
    output logic          take,
    output logic          txd
);
    logic [FW-1:0] sr;
    logic [LW-1:0] left;
    logic          phase;
    logic          step;
    logic          finishing;

    assign step      = busy && (sync ? (fall_ev && phase) : bit_tick);
    assign finishing = step && (left == '0);
    assign take      = run && buf_full && (!busy || finishing);
    assign txd       = sr[0];

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy  <= 1'b0;
            sr    <= '1;
            left  <= '0;
            phase <= 1'b0;
        end else if (run) begin
            if (take) begin
                sr    <= FW'(frame_word(sync, nine, bit9, buf_data));
                left  <= LW'(frame_last(sync, nine));
                busy  <= 1'b1;
                phase <= 1'b0;
            end else if (finishing) begin
                busy  <= 1'b0;
                sr    <= '1;
                phase <= 1'b0;
            end else if (step) begin
                sr    <= {1'b1, sr[FW-1:1]};
                left  <= left - LW'(1);
                phase <= 1'b0;
            end else if (sync && rise_ev) begin
                phase <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sertx_top.sv
`timescale 1ns/1ps
module sertx_top
    import sertx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       port_en,
    input  logic       reg_we,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       dat_we,
    input  logic [7:0] dat_wdata,
    input  logic       rx_single_en,
    input  logic       rx_cont_en,
    output logic       txd_o,
    output logic       txd_oe,
    input  logic       ck_i,
    output logic       ck_o,
    output logic       ck_oe
);
    ctl_t              ctl;
    logic [DIV_W-1:0]  div;
    logic              buf_full;
    logic [DATA_W-1:0] buf_data;
    logic              busy;
    logic              take;
    logic              trmt;
    logic              tick;
    logic              rise_ev;
    logic              fall_ev;
    logic              ck_drv;
    logic              txd;
    logic              ovr;
    logic              run;
    logic              master;
    logic [CNT_W-1:0]  limit;

    assign ovr    = ctl.sync_mode && (rx_single_en || rx_cont_en);
    assign run    = ctl.tx_on && !ovr;
    assign master = ctl.sync_mode && ctl.clk_master;
    assign limit  = tick_limit(ctl.sync_mode, ctl.fast, div);
    assign trmt   = !busy;

    sertx_regs #(.DW(DATA_W), .VW(DIV_W)) i_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
        .take(take), .trmt(trmt), .ctl(ctl), .div(div),
        .buf_full(buf_full), .buf_data(buf_data), .rdata(reg_rdata)
    );

    sertx_baud #(.CW(CNT_W)) i_baud (
        .clk(clk), .rst(rst), .clear(!busy), .run(run),
        .limit(limit), .tick(tick)
    );

    sertx_clock #(.STAGES(SYNC_STAGES)) i_clock (
        .clk(clk), .rst(rst), .master(master), .busy(busy),
        .active(busy && run), .tick(tick), .ck_pin(ck_i),
        .rise_ev(rise_ev), .fall_ev(fall_ev), .ck_drv(ck_drv)
    );

    sertx_shift #(.DW(DATA_W), .FW(FRAME_W), .LW(LEFT_W)) i_shift (
        .clk(clk), .rst(rst), .abort(!ctl.tx_on), .run(run),
        .sync(ctl.sync_mode), .nine(ctl.nine), .bit9(ctl.bit9),
        .buf_full(buf_full), .buf_data(buf_data), .bit_tick(tick),
        .rise_ev(rise_ev), .fall_ev(fall_ev),
        .busy(busy), .take(take), .txd(txd)
    );

    assign txd_o  = txd;
    assign txd_oe = port_en && !ovr;
    assign ck_o   = ck_drv;
    assign ck_oe  = port_en && master && !ovr;
endmodule

// File: rtl/sertx_chk.sv
`timescale 1ns/1ps
module sertx_chk (
    input logic       clk,
    input logic       rst,
    input logic       port_en,
    input logic       sync_m,
    input logic       tx_on,
    input logic       reg_we,
    input logic       rx_any,
    input logic       trmt,
    input logic       reg_addr,
    input logic [7:0] reg_rdata,
    input logic       txd_o,
    input logic       txd_oe,
    input logic       ck_o,
    input logic       ck_oe
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 1'b0) |-> (reg_rdata[3] == 1'b0)); // R2
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (rst)
        trmt |-> txd_o); // R3
    AST_TXOFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!tx_on && !reg_we) |=> trmt); // R6
    AST_CK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        trmt |-> !ck_o); // R7
    AST_CK_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        (ck_oe && $rose(ck_o)) |-> $stable(txd_o)); // R7
    AST_OVR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sync_m && rx_any) |-> (!txd_oe && !ck_oe)); // R9
    AST_OVR_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (sync_m && rx_any && tx_on && !reg_we) |=> $stable(trmt)); // R9
    AST_PORT_OFF: assert property (@(posedge clk) disable iff (rst)
        !port_en |-> (!txd_oe && !ck_oe)); // R10
    AST_ASYNC_NO_CK: assert property (@(posedge clk) disable iff (rst)
        !sync_m |-> !ck_oe); // R11
endmodule

bind sertx_top sertx_chk i_chk (
    .clk(clk), .rst(rst), .port_en(port_en),
    .sync_m(ctl.sync_mode), .tx_on(ctl.tx_on), .reg_we(reg_we),
    .rx_any(rx_single_en || rx_cont_en), .trmt(trmt),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .txd_o(txd_o), .txd_oe(txd_oe), .ck_o(ck_o), .ck_oe(ck_oe)
);

// File: tb/test_sertx_top.sv
`timescale 1ns/1ps
module test_sertx_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       port_en = 1'b1;
    logic       reg_we = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       dat_we = 1'b0;
    logic [7:0] dat_wdata = '0;
    logic       rx_single_en = 1'b0;
    logic       rx_cont_en = 1'b0;
    logic       txd_o, txd_oe, ck_o, ck_oe;
    logic       ck_i = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sertx_top i_sertx_top (
        .clk(clk), .rst(rst), .port_en(port_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .rx_single_en(rx_single_en),
        .rx_cont_en(rx_cont_en), .txd_o(txd_o), .txd_oe(txd_oe),
        .ck_i(ck_i), .ck_o(ck_o), .ck_oe(ck_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] d);
        @(negedge clk);
        dat_we = 1'b1; dat_wdata = d;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    function automatic int per_async(input bit fast, input int dv);
        return (dv + 1) * (fast ? 16 : 64);
    endfunction

    function automatic logic [8:0] exp_word(input bit nine, input bit b9, input logic [7:0] d);
        return nine ? {b9, d} : {1'b0, d};
    endfunction

    // Receives one async frame; samples every bit at its middle.
    task automatic rx_async(input int p, input int nb, input bit find_start, output logic [8:0] val);
        val = '0;
        if (find_start) begin
            do @(negedge clk); while (txd_o !== 1'b0);
            repeat (p / 2) @(negedge clk);
        end else begin
            repeat (p) @(negedge clk);
        end
        chk(txd_o == 1'b0, "R3 start bit low", 32'(txd_o), 0);
        for (int i = 0; i < nb; i++) begin
            repeat (p) @(negedge clk);
            val[i] = txd_o;
        end
        repeat (p) @(negedge clk);
        chk(txd_o == 1'b1, "R3 stop bit high", 32'(txd_o), 1);
        chk(reg_rdata[1] == 1'b0, "R5 status busy during stop", 32'(reg_rdata[1]), 0);
    endtask

    // Collects nb bits at the rising edges of ck_o; reports the last edge spacing.
    task automatic rx_sm(input int nb, output logic [8:0] val, output int per);
        logic prev;
        int   cnt;
        int   last;
        int   got;
        val = '0; per = 0; cnt = 0; last = -1; got = 0;
        prev = ck_o;
        while (got < nb) begin
            @(negedge clk);
            cnt++;
            if (!prev && ck_o) begin
                val[got] = txd_o;
                if (last >= 0) per = cnt - last;
                last = cnt;
                got++;
            end
            prev = ck_o;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [8:0] v, v2;
        int per;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(reg_rdata == 8'h02, "R1 control reset value", 32'(reg_rdata), 32'h02);
        chk(txd_o == 1'b1 && ck_o == 1'b0, "R1 line idle", {txd_o, ck_o}, 32'b10);

        // R2 register layout
        wr_reg(1'b0, 8'hFF);
        #1 chk(reg_rdata == 8'hF7, "R2 reserved zero, status read-only", 32'(reg_rdata), 32'hF7);
        wr_reg(1'b0, 8'h00);
        #1 chk(reg_rdata == 8'h02, "R2 status bit ignores writes", 32'(reg_rdata), 32'h02);
        wr_reg(1'b1, 8'h5A);
        @(negedge clk); reg_addr = 1'b1;
        #1 chk(reg_rdata == 8'h5A, "R2 reload readback", 32'(reg_rdata), 32'h5A);
        reg_addr = 1'b0;

        // R3 directed fast async frame, reload 0 -> 16 clocks per bit
        wr_reg(1'b1, 8'h00);
        wr_reg(1'b0, 8'h24);
        wr_dat(8'hA5);
        rx_async(16, 8, 1'b1, v);
        chk(v == 9'h0A5, "R3 async data LSB first", 32'(v), 32'hA5);
        repeat (16) @(negedge clk);
        chk(reg_rdata[1] == 1'b1, "R5 status empty after frame", 32'(reg_rdata[1]), 1);

        // R3 slow speed: 64 clocks per bit
        wr_reg(1'b0, 8'h20);
        wr_dat(8'h3E);
        rx_async(64, 8, 1'b1, v);
        chk(v == 9'h03E, "R3 slow speed frame", 32'(v), 32'h3E);
        repeat (64) @(negedge clk);

        // R3 R4 R11 random async frames
        for (int k = 0; k < 6; k++) begin
            int         dv;
            bit         fast, nine, b9, csrc;
            logic [7:0] d;
            dv   = $urandom_range(0, 3);
            fast = 1'($urandom_range(0, 1));
            nine = 1'($urandom_range(0, 1));
            b9   = 1'($urandom_range(0, 1));
            csrc = 1'($urandom_range(0, 1));
            d    = 8'($urandom_range(0, 255));
            wr_reg(1'b1, 8'(dv));
            wr_reg(1'b0, {csrc, nine, 1'b1, 1'b0, 1'b0, fast, 1'b0, b9});
            wr_dat(d);
            rx_async(per_async(fast, dv), nine ? 9 : 8, 1'b1, v);
            chk(v == exp_word(nine, b9, d), "R4 random async word", 32'(v), 32'(exp_word(nine, b9, d)));
            chk(ck_oe == 1'b0, "R11 clock master ignored in async", 32'(ck_oe), 0);
            repeat (per_async(fast, dv)) @(negedge clk);
        end

        // R5 back-to-back frames
        wr_reg(1'b1, 8'h00);
        wr_reg(1'b0, 8'h24);
        wr_dat(8'h11);
        do @(negedge clk); while (reg_rdata[1] !== 1'b0);
        wr_dat(8'h22);
        rx_async(16, 8, 1'b1, v);
        rx_async(16, 8, 1'b0, v2);
        chk(v == 9'h011, "R5 first of pair", 32'(v), 32'h11);
        chk(v2 == 9'h022, "R5 second follows stop with no gap", 32'(v2), 32'h22);
        repeat (16) @(negedge clk);
        chk(reg_rdata[1] == 1'b1, "R5 status empty after pair", 32'(reg_rdata[1]), 1);

        // R6 transmit disabled holds the buffer
        wr_reg(1'b0, 8'h04);
        wr_dat(8'h5C);
        repeat (100) @(negedge clk);
        chk(txd_o == 1'b1 && reg_rdata[1] == 1'b1, "R6 no transmission while disabled",
            {txd_o, reg_rdata[1]}, 32'b11);
        wr_reg(1'b0, 8'h24);
        rx_async(16, 8, 1'b1, v);
        chk(v == 9'h05C, "R6 held byte sent on enable", 32'(v), 32'h5C);
        repeat (16) @(negedge clk);

        // R7 synchronous master, reload 1 -> period 8
        wr_reg(1'b1, 8'h01);
        wr_reg(1'b0, 8'hB4);
        chk(ck_oe == 1'b1 && ck_o == 1'b0, "R7 master drives idle-low clock", {ck_oe, ck_o}, 32'b10);
        wr_dat(8'h3C);
        rx_sm(8, v, per);
        chk(v == 9'h03C, "R7 master data LSB first", 32'(v), 32'h3C);
        chk(per == 8, "R7 master clock period", 32'(per), 8);
        repeat (10) @(negedge clk);
        chk(reg_rdata[1] == 1'b1 && ck_o == 1'b0, "R7 master done, clock low",
            {reg_rdata[1], ck_o}, 32'b10);

        // R7 R4 speed bit ignored, nine bits
        wr_reg(1'b0, 8'hF1);
        wr_dat(8'hC3);
        rx_sm(9, v, per);
        chk(v == 9'h1C3, "R4 sync ninth bit", 32'(v), 32'h1C3);
        chk(per == 8, "R7 speed bit no effect in sync", 32'(per), 8);
        repeat (10) @(negedge clk);

        // R10 port disable
        port_en = 1'b0;
        #1 chk(txd_oe == 1'b0 && ck_oe == 1'b0, "R10 pins released", {txd_oe, ck_oe}, 0);
        port_en = 1'b1;

        // R9 receive override freezes a master word
        wr_reg(1'b0, 8'hB0);
        wr_dat(8'h81);
        begin
            logic prev, ck_hold;
            int   got, moved;
            v = '0; got = 0; moved = 0;
            prev = ck_o;
            while (got < 2) begin
                @(negedge clk);
                if (!prev && ck_o) begin v[got] = txd_o; got++; end
                prev = ck_o;
            end
            rx_single_en = 1'b1;
            #1 chk(txd_oe == 1'b0 && ck_oe == 1'b0, "R9 pins released on override",
                   {txd_oe, ck_oe}, 0);
            ck_hold = ck_o;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (ck_o != ck_hold || reg_rdata[1] != 1'b0) moved++;
            end
            chk(moved == 0, "R9 word frozen during override", 32'(moved), 0);
            rx_single_en = 1'b0;
            prev = ck_o;
            while (got < 8) begin
                @(negedge clk);
                if (!prev && ck_o) begin v[got] = txd_o; got++; end
                prev = ck_o;
            end
            chk(v == 9'h081, "R9 word intact after override", 32'(v), 32'h81);
        end
        repeat (10) @(negedge clk);
        chk(reg_rdata[1] == 1'b1, "R9 word completes", 32'(reg_rdata[1]), 1);

        // R8 synchronous slave
        wr_reg(1'b0, 8'h30);
        chk(ck_oe == 1'b0, "R8 slave does not drive clock", 32'(ck_oe), 0);
        wr_dat(8'h96);
        repeat (4) @(negedge clk);
        begin
            int errs;
            errs = 0;
            for (int i = 0; i < 8; i++) begin
                if (txd_o != 1'((8'h96 >> i) & 1)) errs++;
                ck_i = 1'b1;
                repeat (8) @(negedge clk);
                ck_i = 1'b0;
                repeat (8) @(negedge clk);
            end
            chk(errs == 0, "R8 slave bits follow external falling edges", 32'(errs), 0);
        end
        chk(reg_rdata[1] == 1'b1, "R8 slave status empty after last edge", 32'(reg_rdata[1]), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule